// File: doc/BRIEF.md
# Half-Line Zero-Crossing Synchronizer

This block finds the start of each half-period of a rectified mains waveform and emits a one-cycle restart pulse. A table-driven duty-cycle sequencer uses that pulse to restart its indexing. The block does not look for the voltage minimum directly. It compares each voltage sample against a threshold and measures how many samples in a row lie below it. Because the rectified waveform is symmetric about the crossing, the crossing sits halfway through that low stretch.

The middle of an interval is only known once the interval has ended. For that reason, the block uses the length measured in the previous low interval. It fires the pulse once the running count inside the current interval reaches half of that stored length. A short run of below-threshold samples is treated as noise and ignored. The first interval after reset only provides a length to work from. A polarity flag flips with every pulse, so downstream logic can tell alternate half-periods apart.

Top module: `zc_sync`

## Requirements
- R1: A sample counts as below threshold only when it is strictly less than `thresh_i`. A sample equal to the threshold counts as above.
- R2: Only cycles with `smp_valid_i` high are evaluated. Samples on other cycles have no effect on intervals, pulses or polarity.
- R3: A low interval begins only when FILT_N consecutive valid samples are below threshold. A shorter run produces no pulse and leaves the stored length unchanged.
- R4: An interval's length is its number of below-threshold samples, counting the filter samples. The count saturates at 2^CNT_W-1 and never wraps.
- R5: The first recognized low interval after reset produces no restart pulse.
- R6: With P the stored length of the previous interval, the pulse follows the below sample with index max(floor(P/2), FILT_N) within the current interval (1-based). `restart_o` is high during the clock cycle right after the edge that captured that sample.
- R7: There is at most one pulse per interval, and each pulse lasts one clock cycle. If the interval ends before the target index is reached, there is no pulse.
- R8: `polarity_o` is 0 after reset and inverts on the same edge that raises `restart_o`.
- R9: Synchronous reset drives both outputs low and discards the stored interval length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Marks a cycle carrying a new voltage sample |
| smp_i | input | SAMPLE_W | Unsigned rectified voltage sample |
| thresh_i | input | SAMPLE_W | Comparison threshold |
| restart_o | output | 1 | One-cycle half-period restart pulse |
| polarity_o | output | 1 | Half-period parity flag |

## Verification
The bench builds the block with SAMPLE_W=8, CNT_W=8 and FILT_N=3. The 8-bit counter lets a run of a few hundred samples hit saturation at 255, so the no-wrap rule and the stored saturated length can both be checked. A filter of three samples sits above some halved lengths and below others, so both sides of the max() in the pulse index are exercised. It also allows a two-sample glitch to be rejected. Idle cycles carrying a zero sample with the strobe low are placed between every valid sample.

// File: rtl/zc_pkg.sv
package zc_pkg;

    // Per-sample event decoded by the glitch filter
    typedef struct packed {
        logic enter;   // this sample completes the filter run: interval opens
        logic stay;    // below sample inside an open interval
        logic leave;   // first non-below sample closing an open interval
    } zc_evt_t;

    function automatic logic evt_in_low(zc_evt_t e);
        return e.enter | e.stay;
    endfunction

    function automatic logic is_below(logic [31:0] smp, logic [31:0] thr);
        return smp < thr;
    endfunction

endpackage

// File: rtl/zc_glitch_filter.sv
module zc_glitch_filter
    import zc_pkg::*;
#(
    parameter int FILT_N = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    valid_i,
    input  logic    below_i,
    output zc_evt_t evt_o
);
    localparam int RUN_W = $clog2(FILT_N + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(FILT_N);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;
    logic             in_low_q;

    assign run_inc = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;

    always_comb begin
        evt_o.enter = valid_i & below_i & ~in_low_q & (run_inc == RUN_MAX);
        evt_o.stay  = valid_i & below_i & in_low_q;
        evt_o.leave = valid_i & ~below_i & in_low_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            in_low_q <= 1'b0;
        end else if (valid_i) begin
            if (below_i) begin
                run_q <= run_inc;
                if (evt_o.enter) in_low_q <= 1'b1;
            end else begin
                run_q    <= '0;
                in_low_q <= 1'b0;
            end
        end
    end

    // R3: an interval opens only on a valid below sample
    assert_open_on_below_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_low_q) |-> $past(valid_i && below_i));

endmodule

// File: rtl/zc_interval_meter.sv
module zc_interval_meter
    import zc_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int FILT_N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  zc_evt_t          evt_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic [CNT_W-1:0] half_o,
    output logic             seeded_o
);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FILT_N);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] prev_q;
    logic             seeded_q;
    logic             stay;

    assign stay = evt_i.stay;

    always_comb begin
        if (evt_i.enter)     cnt_next_o = CNT_LOAD;
        else if (stay)       cnt_next_o = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        else                 cnt_next_o = cnt_q;
    end

    assign half_o   = prev_q >> 1;
    assign seeded_o = seeded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            prev_q   <= '0;
            seeded_q <= 1'b0;
        end else begin
            cnt_q <= cnt_next_o;
            if (evt_i.leave) begin
                prev_q   <= cnt_q;
                seeded_q <= 1'b1;
            end
        end
    end

    // R4: the running count never drops while an interval stays open
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        $past(stay) |-> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/zc_restart_gen.sv
module zc_restart_gen
    import zc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  zc_evt_t          evt_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] half_i,
    input  logic             seeded_i,
    output logic             restart_o,
    output logic             polarity_o
);
    logic fired_q;
    logic fire;
    logic in_low;

    assign in_low = evt_in_low(evt_i);
    assign fire   = in_low & seeded_i & (~fired_q | evt_i.enter)
                  & (cnt_next_i >= half_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            fired_q    <= 1'b0;
            restart_o  <= 1'b0;
            polarity_o <= 1'b0;
        end else begin
            restart_o <= fire;
            if (fire) polarity_o <= ~polarity_o;
            if (evt_i.enter)  fired_q <= fire;
            else if (fire)    fired_q <= 1'b1;
        end
    end

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> !restart_o);

    assert_pol_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (polarity_o != $past(polarity_o)) |-> restart_o);

    assert_pol_flips_R8: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> (polarity_o != $past(polarity_o)));

    assert_from_sample_R2: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> $past(in_low));

    assert_needs_seed_R5: assert property (@(posedge clk) disable iff (rst)
        restart_o |-> $past(seeded_i));

endmodule

// File: rtl/zc_sync.sv
module zc_sync
    import zc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 24,
    parameter int FILT_N   = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic [SAMPLE_W-1:0] thresh_i,
    output logic                restart_o,
    output logic                polarity_o
);
    zc_evt_t          evt;
    logic             below;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] half;
    logic             seeded;

    // R1: strict comparison
    assign below = is_below(32'(smp_i), 32'(thresh_i));

    zc_glitch_filter #(.FILT_N(FILT_N)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .valid_i (smp_valid_i),
        .below_i (below),
        .evt_o   (evt)
    );

    zc_interval_meter #(.CNT_W(CNT_W), .FILT_N(FILT_N)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .cnt_next_o (cnt_next),
        .half_o     (half),
        .seeded_o   (seeded)
    );

    zc_restart_gen #(.CNT_W(CNT_W)) u_gen (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .cnt_next_i (cnt_next),
        .half_i     (half),
        .seeded_i   (seeded),
        .restart_o  (restart_o),
        .polarity_o (polarity_o)
    );

endmodule

// File: tb/sim_zc_sync.sv
module sim_zc_sync;
    localparam int SW = 8;
    localparam int CW = 8;
    localparam int FN = 3;
    localparam int CMAX = (1 << CW) - 1;
    localparam logic [SW-1:0] THR = 8'd100;

    typedef struct packed {
        logic [7:0]  aval;
        logic [7:0]  bval;
        logic [15:0] len;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [0:NV-1] = '{
        '{8'd180, 8'd20, 16'd10},   // seed only
        '{8'd180, 8'd20, 16'd10},   // half 5
        '{8'd255, 8'd0,  16'd20},   // half 5
        '{8'd180, 8'd20, 16'd4},    // ends before half 10
        '{8'd180, 8'd99, 16'd6},    // half 2 -> filter 3
        '{8'd180, 8'd20, 16'd2},    // glitch
        '{8'd101, 8'd20, 16'd8},    // half 3
        '{8'd180, 8'd20, 16'd300},  // saturates
        '{8'd180, 8'd20, 16'd200},  // half 127
        '{8'd180, 8'd20, 16'd7},    // no pulse
        '{8'd100, 8'd20, 16'd9}     // equal counts above, half 3
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid_i = 1'b0;
    logic [SW-1:0] smp_i = '0;
    logic [SW-1:0] thresh_i = THR;
    logic          restart_o;
    logic          polarity_o;

    int n_chk = 0;
    int n_bad = 0;
    int pulses, pulse_idx, bcnt;
    int prev_len, exp_pol;
    bit seeded;

    always #2 clk = ~clk;

    zc_sync #(.SAMPLE_W(SW), .CNT_W(CW), .FILT_N(FN)) u0 (
        .clk(clk), .rst(rst), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
        .thresh_i(thresh_i), .restart_o(restart_o), .polarity_o(polarity_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [SW-1:0] v, input logic vld);
        @(negedge clk);
        smp_i = v;
        smp_valid_i = vld;
        @(posedge clk);
        #1;
        if (restart_o) begin
            pulses++;
            pulse_idx = bcnt;
        end
    endtask

    // one valid sample followed by an idle cycle carrying a zero sample (R2)
    task automatic put(input logic [SW-1:0] v);
        step(v, 1'b1);
        step('0, 1'b0);
    endtask

    task automatic run_interval(input int aval, input int bval, input int len, input string tag);
        int exp_n, exp_i, tgt, half;
        pulses = 0; pulse_idx = -1; bcnt = 0;
        for (int k = 0; k < 5; k++) put(SW'(aval));
        for (int k = 0; k < len; k++) begin
            bcnt = k + 1;
            put(SW'(bval));
        end
        put(SW'(aval));
        exp_n = 0; exp_i = -1;
        if (len >= FN) begin
            half = prev_len / 2;
            tgt  = (half > FN) ? half : FN;
            if (seeded && tgt <= len) begin
                exp_n = 1; exp_i = tgt;
            end
            prev_len = (len > CMAX) ? CMAX : len;
            seeded = 1'b1;
        end
        exp_pol ^= exp_n;
        check(pulses == exp_n, {tag, " R5 R6 R7 pulse count"}, pulses, exp_n);
        check(pulse_idx == exp_i, {tag, " R1 R3 R4 R6 pulse index"}, pulse_idx, exp_i);
        check(int'(polarity_o) == exp_pol, {tag, " R8 polarity"}, polarity_o, exp_pol);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        prev_len = 0; seeded = 1'b0; exp_pol = 0;
        repeat (3) @(posedge clk);
        #1;
        check(restart_o == 1'b0, "R9 reset restart", restart_o, 0);
        check(polarity_o == 1'b0, "R8 R9 reset polarity", polarity_o, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_interval(TBL[i].aval, TBL[i].bval, TBL[i].len, $sformatf("vec%0d", i));

        // R9: reset in mid-stream forgets the stored length
        for (int k = 0; k < 4; k++) put(8'd10);
        @(negedge clk);
        rst = 1'b1;
        smp_valid_i = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        check(restart_o == 1'b0 && polarity_o == 1'b0, "R9 mid reset outputs",
              {restart_o, polarity_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        prev_len = 0; seeded = 1'b0; exp_pol = 0;
        run_interval(180, 20, 10, "post-reset R9");
        run_interval(180, 20, 12, "post-reset");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule